// File: doc/BRIEF.md
# Post-Configuration Startup Sequencer

This block runs the short startup sequence that follows the loading of a programmable logic device. After a start pulse, a three-bit phase counter steps from phase 0 to phase 7, one step per clock edge. Three global events are released along the way: the I/O three-state release, the global write enable, and the done output. Each event is tied to a phase chosen in the configuration word. An event can also be set to follow the done output, or to stay at its reset value.

The sequencer can hold in a chosen phase until a clock-lock input is high. It can also hold in a chosen phase until an impedance-match input is high. The match phase can be picked automatically: it resolves to phase 2 when impedance-matched I/O is in use, and to no wait otherwise. With the done-pipe option on, the sequencer holds in the done phase until the sampled done pin reads high. It then takes one more edge before done asserts. A complete flag rises once phase 7 has been left.

The configuration word is expected to be static while a sequence runs. One clock domain is used per build.

Top module: `startup_seq`

## Requirements
- R1: After reset, all four outputs are low. Nothing advances until start_i is sampled high.
- R2: Edge E0 is the edge that samples start_i high. With no stall programmed, complete_o rises at edge E8.
- R3: Event select codes 1 to 6 place the event at that phase. Edge Es is the one that enters phase s, and the event output rises there. The fields are done_sel at cfg_i[2:0], io_sel at cfg_i[5:3] and gwe_sel at cfg_i[8:6]. The default word is io 5, gwe 6, done 4.
- R4: A select code of 0 means keep: that output never rises. For done_sel, code 7 is also treated as keep.
- R5: For io_sel and gwe_sel, code 7 means follow done: the event rises on the same edge as done_o. If done is kept, the event never rises.
- R6: The lock-wait phase is set by cfg_i[11:9]. Values 0 to 6 hold the sequence in that phase until lock_i is high. A value of 7 never stalls, whatever lock_i does.
- R7: The match-wait phase is set by cfg_i[14:12] and follows the same rule with match_i. There is no limit on how long the stall lasts.
- R8: When lock and match waits name the same phase, the sequence advances only on an edge where both inputs are high.
- R9: When cfg_i[15] (auto match) is 1, cfg_i[14:12] is ignored. The match phase becomes 2 if cfg_i[16] (impedance I/O in use) is 1, and no wait otherwise.
- R10: When cfg_i[17] (done pipe) is 1, the sequence holds in the done phase until an edge samples done_pin_i high. done_o rises, and the phase advances, on the next edge.
- R11: Once high, io_release_o, gwe_o, done_o and complete_o stay high until reset. A start pulse while running or after completion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Startup clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| lock_i | input | 1 | Clock-lock status |
| match_i | input | 1 | Impedance-match status |
| done_pin_i | input | 1 | Sampled level of the external done pin |
| cfg_i | input | 18 | Configuration word |
| io_release_o | output | 1 | I/O three-state release |
| gwe_o | output | 1 | Global write enable |
| done_o | output | 1 | Done drive |
| complete_o | output | 1 | Sequence complete |

## Verification
Counting from E0, an event at phase s is due at edge s plus all stall edges spent in earlier phases. A lock or match stall at phase p adds one edge for each edge on which the needed input is still low. The done pipe adds one edge of waiting after the done pin is sampled high, and the done output rises on the edge after that. The bench drives each status input at the falling edge after a known edge count, samples all outputs at each later falling edge, and records the first edge index at which each output is high. It then compares those indices with values worked out by hand from these rules, and flags any output that falls after rising.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int PH_W    = 3;
  localparam int SEL_W   = 3;
  localparam int N_EVT   = 2;
  localparam int CFG_W   = 3 + 5 * SEL_W;

  typedef logic [PH_W-1:0]  phase_t;
  typedef logic [SEL_W-1:0] sel_t;

  localparam phase_t LAST_PH      = phase_t'((1 << PH_W) - 1);
  localparam sel_t   SEL_KEEP     = sel_t'(0);
  localparam sel_t   SEL_FOLLOW   = sel_t'((1 << SEL_W) - 1);
  localparam sel_t   WAIT_NONE    = sel_t'((1 << SEL_W) - 1);
  localparam sel_t   AUTO_MATCH_PH = sel_t'(2);

  typedef struct packed {
    logic done_pipe;
    logic imp_used;
    logic match_auto;
    sel_t match_ph;
    sel_t lock_ph;
    sel_t gwe_sel;
    sel_t io_sel;
    sel_t done_sel;
  } sup_cfg_t;

  localparam sup_cfg_t SUP_CFG_DEFAULT = '{1'b0, 1'b0, 1'b0, WAIT_NONE, WAIT_NONE,
                                           sel_t'(6), sel_t'(5), sel_t'(4)};

  function automatic logic sel_is_phase(sel_t s);
    return (s != SEL_KEEP) && (s != SEL_FOLLOW);
  endfunction
endpackage

// File: rtl/sup_phase_ctrl.sv
module sup_phase_ctrl
  import sup_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   lock_i,
  input  logic   match_i,
  input  logic   done_pin_i,
  input  sel_t   lock_ph_i,
  input  sel_t   match_ph_i,
  input  logic   match_auto_i,
  input  logic   imp_used_i,
  input  logic   done_pipe_i,
  input  sel_t   done_sel_i,
  output phase_t phase_o,
  output phase_t nxt_phase_o,
  output logic   adv_o,
  output logic   pipe_o,
  output logic   cmpl_o
);
  phase_t phase_q;
  logic   run_q, pipe_q, cmpl_q;
  sel_t   match_eff;
  logic   lock_stall, match_stall, pipe_hold, pipe_phase, adv;

  always_comb begin
    if (match_auto_i) match_eff = imp_used_i ? AUTO_MATCH_PH : WAIT_NONE;
    else              match_eff = match_ph_i;
  end

  assign pipe_phase  = done_pipe_i && sel_is_phase(done_sel_i) && (phase_q == done_sel_i);
  assign lock_stall  = (lock_ph_i != WAIT_NONE) && (phase_q == lock_ph_i) && !lock_i;
  assign match_stall = (match_eff != WAIT_NONE) && (phase_q == match_eff) && !match_i;
  assign pipe_hold   = pipe_phase && !pipe_q;
  assign adv         = run_q && !lock_stall && !match_stall && !pipe_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      run_q   <= 1'b0;
      pipe_q  <= 1'b0;
      cmpl_q  <= 1'b0;
    end else begin
      if (!run_q && !cmpl_q && start_i) begin
        run_q   <= 1'b1;
        phase_q <= '0;
      end else if (adv) begin
        if (phase_q == LAST_PH) begin
          run_q  <= 1'b0;
          cmpl_q <= 1'b1;
        end else begin
          phase_q <= phase_q + phase_t'(1);
        end
      end
      if (run_q && pipe_phase && done_pin_i) pipe_q <= 1'b1;
    end
  end

  assign phase_o     = phase_q;
  assign nxt_phase_o = phase_q + phase_t'(1);
  assign adv_o       = adv;
  assign pipe_o      = pipe_q;
  assign cmpl_o      = cmpl_q;

  assert_lock_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && lock_ph_i != WAIT_NONE && phase_q == lock_ph_i && !lock_i
    |=> run_q && phase_q == $past(phase_q));

  assert_match_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !match_auto_i && match_ph_i != WAIT_NONE && phase_q == match_ph_i && !match_i
    |=> run_q && phase_q == $past(phase_q));

  assert_auto_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && match_auto_i && imp_used_i && phase_q == AUTO_MATCH_PH && !match_i
    |=> phase_q == AUTO_MATCH_PH);

  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) && phase_q != $past(phase_q)
    |-> phase_q == phase_t'($past(phase_q) + phase_t'(1)));

  assert_cmpl_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_q |=> cmpl_q && !run_q);

  assert_cmpl_from_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmpl_q) |-> $past(phase_q) == LAST_PH);
endmodule

// File: rtl/sup_done.sv
module sup_done
  import sup_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sel_t   done_sel_i,
  input  logic   done_pipe_i,
  input  logic   adv_i,
  input  phase_t phase_i,
  input  phase_t nxt_phase_i,
  input  logic   pipe_i,
  output logic   set_o,
  output logic   done_o
);
  logic done_q, set;

  always_comb begin
    set = 1'b0;
    if (sel_is_phase(done_sel_i) && adv_i) begin
      if (done_pipe_i) set = (phase_i == done_sel_i);
      else             set = (nxt_phase_i == done_sel_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  done_q <= 1'b0;
    else if (set) done_q <= 1'b1;
  end

  assign set_o  = set;
  assign done_o = done_q;

  assert_done_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  assert_done_pipe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) && done_pipe_i |-> $past(pipe_i));

  assert_done_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_is_phase(done_sel_i) |-> !done_q);
endmodule

// File: rtl/sup_event.sv
module sup_event
  import sup_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sel_t   sel_i,
  input  logic   adv_i,
  input  phase_t nxt_phase_i,
  input  logic   done_set_i,
  input  logic   done_i,
  output logic   ev_o
);
  logic ev_q, set;

  always_comb begin
    if (sel_i == SEL_FOLLOW)   set = done_set_i;
    else if (sel_is_phase(sel_i)) set = adv_i && (nxt_phase_i == sel_i);
    else                       set = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ev_q <= 1'b0;
    else if (set) ev_q <= 1'b1;
  end

  assign ev_o = ev_q;

  assert_ev_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q |=> ev_q);

  assert_ev_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_KEEP |-> !ev_q);

  assert_ev_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_FOLLOW && $rose(ev_q) |-> $rose(done_i));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import sup_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             lock_i,
  input  logic             match_i,
  input  logic             done_pin_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             io_release_o,
  output logic             gwe_o,
  output logic             done_o,
  output logic             complete_o
);
  sup_cfg_t cfg;
  phase_t   phase, nxt_phase;
  logic     adv, pipe, done_set, done;
  sel_t     ev_sel [N_EVT];
  logic     ev_out [N_EVT];

  assign cfg       = sup_cfg_t'(cfg_i);
  assign ev_sel[0] = cfg.io_sel;
  assign ev_sel[1] = cfg.gwe_sel;

  sup_phase_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .lock_i       (lock_i),
    .match_i      (match_i),
    .done_pin_i   (done_pin_i),
    .lock_ph_i    (cfg.lock_ph),
    .match_ph_i   (cfg.match_ph),
    .match_auto_i (cfg.match_auto),
    .imp_used_i   (cfg.imp_used),
    .done_pipe_i  (cfg.done_pipe),
    .done_sel_i   (cfg.done_sel),
    .phase_o      (phase),
    .nxt_phase_o  (nxt_phase),
    .adv_o        (adv),
    .pipe_o       (pipe),
    .cmpl_o       (complete_o)
  );

  sup_done u_done (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_sel_i  (cfg.done_sel),
    .done_pipe_i (cfg.done_pipe),
    .adv_i       (adv),
    .phase_i     (phase),
    .nxt_phase_i (nxt_phase),
    .pipe_i      (pipe),
    .set_o       (done_set),
    .done_o      (done)
  );

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    sup_event u_evt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (ev_sel[g]),
      .adv_i       (adv),
      .nxt_phase_i (nxt_phase),
      .done_set_i  (done_set),
      .done_i      (done),
      .ev_o        (ev_out[g])
    );
  end

  assign io_release_o = ev_out[0];
  assign gwe_o        = ev_out[1];
  assign done_o       = done;
endmodule

// File: tb/startup_seq_bench.sv
module startup_seq_bench;
  import sup_pkg::*;

  logic clk = 1'b0;
  logic rst_ni, start_i, lock_i, match_i, done_pin_i;
  logic [CFG_W-1:0] cfg_i;
  logic io_release_o, gwe_o, done_o, complete_o;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  startup_seq u_startup_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .lock_i(lock_i),
    .match_i(match_i), .done_pin_i(done_pin_i), .cfg_i(cfg_i),
    .io_release_o(io_release_o), .gwe_o(gwe_o), .done_o(done_o),
    .complete_o(complete_o)
  );

  function automatic logic [CFG_W-1:0] mk_cfg(logic pipe, logic imp, logic aut,
      int mph, int lph, int gwe, int io, int dn);
    return {pipe, imp, aut, 3'(mph), 3'(lph), 3'(gwe), 3'(io), 3'(dn)};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; start_i = 1'b0; lock_i = 1'b0; match_i = 1'b0; done_pin_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // First edge index (E0 = start edge) at which each output reads high; -1 if never.
  task automatic run_seq(string req, logic [CFG_W-1:0] cfg, int lk, int mt, int pn,
      int restart_k, int e_io, int e_gwe, int e_dn, int e_cm);
    int f_io = -1, f_gwe = -1, f_dn = -1, f_cm = -1, drops = 0;
    do_reset();
    cfg_i   = cfg;
    start_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= 30; k++) begin
      if (k > 0) @(posedge clk);
      @(negedge clk);
      if (io_release_o && f_io < 0) f_io = k;
      if (gwe_o && f_gwe < 0) f_gwe = k;
      if (done_o && f_dn < 0) f_dn = k;
      if (complete_o && f_cm < 0) f_cm = k;
      if ((f_io >= 0 && !io_release_o) || (f_gwe >= 0 && !gwe_o) ||
          (f_dn >= 0 && !done_o) || (f_cm >= 0 && !complete_o)) drops++;
      lock_i     = (k >= lk);
      match_i    = (k >= mt);
      done_pin_i = (k >= pn);
      start_i    = (k == restart_k);
    end
    chk(req, "io_release edge", f_io, e_io);
    chk(req, "gwe edge", f_gwe, e_gwe);
    chk(req, "done edge", f_dn, e_dn);
    chk(req, "complete edge", f_cm, e_cm);
    chk("R11", "outputs falling after rise", drops, 0);
  endtask

  task automatic t_reset_idle();
    do_reset();
    cfg_i = SUP_CFG_DEFAULT;
    lock_i = 1'b1; match_i = 1'b1; done_pin_i = 1'b1;
    repeat (12) @(negedge clk);
    chk("R1", "outputs idle without start",
        int'({io_release_o, gwe_o, done_o, complete_o}), 0);
  endtask

  task automatic t_default();       // R2 R3 R11: restart after completion ignored
    run_seq("R2/R3 default", SUP_CFG_DEFAULT, 99, 99, 99, 20, 5, 6, 4, 8);
  endtask

  task automatic t_permuted();      // R3 R11: restart while running ignored
    run_seq("R3 permuted", mk_cfg(0, 0, 0, 7, 7, 3, 1, 6), 99, 99, 99, 2, 1, 3, 6, 8);
  endtask

  task automatic t_keep_follow();   // R4 R5
    run_seq("R4/R5 keep+follow", mk_cfg(0, 0, 0, 7, 7, 0, 7, 2), 99, 99, 99, -1, 2, -1, 2, 8);
  endtask

  task automatic t_done_kept();     // R4 R5: done code 7 kept, follower never rises
    run_seq("R4/R5 done kept", mk_cfg(0, 0, 0, 7, 7, 6, 7, 7), 99, 99, 99, -1, -1, 6, -1, 8);
  endtask

  task automatic t_lock();          // R6
    run_seq("R6 lock stall", mk_cfg(0, 0, 0, 7, 3, 6, 5, 4), 6, 99, 99, -1, 8, 9, 7, 11);
  endtask

  task automatic t_match();         // R7
    run_seq("R7 match stall", mk_cfg(0, 0, 0, 0, 7, 6, 5, 4), 99, 10, 99, -1, 15, 16, 14, 18);
  endtask

  task automatic t_both();          // R8
    run_seq("R8 both late lock", mk_cfg(0, 0, 0, 2, 2, 6, 5, 4), 7, 4, 99, -1, 10, 11, 9, 13);
    run_seq("R8 both late match", mk_cfg(0, 0, 0, 2, 2, 6, 5, 4), 3, 6, 99, -1, 9, 10, 8, 12);
  endtask

  task automatic t_auto();          // R9
    run_seq("R9 auto imp", mk_cfg(0, 1, 1, 7, 7, 6, 5, 4), 99, 5, 99, -1, 8, 9, 7, 11);
    run_seq("R9 auto none", mk_cfg(0, 0, 1, 1, 7, 6, 5, 4), 99, 99, 99, -1, 5, 6, 4, 8);
  endtask

  task automatic t_pipe();          // R10
    run_seq("R10 pipe early pin", mk_cfg(1, 0, 0, 7, 7, 6, 5, 4), 99, 99, 0, -1, 6, 7, 6, 9);
    run_seq("R10 pipe late pin", mk_cfg(1, 0, 0, 7, 7, 6, 7, 4), 99, 99, 8, -1, 10, 11, 10, 13);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; lock_i = 1'b0; match_i = 1'b0; done_pin_i = 1'b0;
    cfg_i = SUP_CFG_DEFAULT;
    @(negedge clk);
    chk("R1", "outputs in reset", int'({io_release_o, gwe_o, done_o, complete_o}), 0);
    t_reset_idle();
    t_default();
    t_permuted();
    t_keep_follow();
    t_done_kept();
    t_lock();
    t_match();
    t_both();
    t_auto();
    t_pipe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule